// File: doc/BRIEF.md
# Host Interrupt Aggregator with Coalescing

This block collects single-cycle event pulses from the internal sources of a device into a cause register that the host can read. An enable mask decides which of those causes may drive the single level-sensitive interrupt line toward the host. A holdoff timer, counted in units of 32 microsecond ticks, delays the line so that a burst of events costs the host one interrupt instead of many. A high-priority receive event skips that delay.

A second cause register records DMA channel events: receive channels, transmit channels, a high-priority receive flag and a DMA error. Each new DMA event also sets a summary bit in the main register, so the host learns of DMA activity from the main register and then reads the DMA register for detail. A periodic generator can set a periodic-receive cause at a programmable interval. Software reaches everything through a plain word-addressed 32-bit read/write port. A write of 1 clears a cause bit, and a write of 0 leaves it as it is.

Top module: `host_irq_coalescer`

## Requirements
- R1: After reset the main cause (word 0) and DMA cause (word 2) read 0, the enable mask (word 1) reads 0, the timing word (word 3) reads 0x0000_0040, and `host_irq` is low.
- R2: A pulse on `hw_evt` sets the matching main cause bit in the following cycle, for bits 29 (hardware error), 26 (queue pointer advance), 25 (firmware error), 7 (RF-kill toggle), 6 (over-temperature), 3 (software receive), 1 (wakeup) and 0 (alive). All other `hw_evt` bits are ignored, and bits that are not implemented read 0.
- R3: Writing word 0 clears every main cause bit that is 1 in the write data, and leaves every bit that is 0 in the write data. An event arriving in the same cycle as its clear wins, and the bit stays set.
- R4: The DMA cause register (word 2) implements bit 31 (error), bit 30 (high-priority receive), bits 17/16 (receive channels 1/0) and bits 1/0 (transmit channels 1/0). Each is set by the `dma_evt` pulse at the same position and cleared by writing 1 to word 2.
- R5: A DMA event also sets a summary bit in the main cause register. Bits 30, 17 or 16 set main bit 31, bits 1 or 0 set main bit 27, and bit 31 sets main bit 29.
- R6: A cause bit whose enable bit (word 1, same position) is 0 never drives `host_irq`. Enable bits exist only at the implemented main cause positions.
- R7: Word 3 bits [7:0] set the holdoff in units of 32 `us_tick` pulses. When an enabled cause appears while the line is idle, `host_irq` rises after that many unit boundaries. A holdoff of 0 raises the line on the second clock edge after the event pulse.
- R8: While DMA bit 30 and main bit 31 are both set and main bit 31 is enabled, `host_irq` rises on the next clock edge, even when a holdoff is running.
- R9: `host_irq` is low in the same cycle that no enabled main cause bit remains set.
- R10: Word 3 bits [15:8] set the periodic interval P in units. When P is nonzero, main bit 28 is set every P unit boundaries. When P is 0, bit 28 is never set by the generator.
- R11: Words 1 and 3 read back what was written, masked to their implemented bits (word 3 keeps bits [15:0]). Addresses above 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| hw_evt | input | 32 | Event pulses for the main cause register |
| dma_evt | input | 32 | Event pulses for the DMA cause register |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| host_irq | output | 1 | Interrupt line toward the host |

## Verification
The assertions assume that event inputs are single-cycle pulses sampled on the rising edge, and that `us_tick` never stays high for long enough to break the 32-to-1 unit division. The same-cycle rules for a clear that meets an event hold only when the register port and the events change together, away from the edge. The bench drives every input on the falling edge, uses pulses for all events, and runs one stress phase where `us_tick` toggles instead of staying high. A behavioural model follows every register and the line cycle by cycle.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int unsigned REG_W = 32;

  // main cause bit positions
  localparam int unsigned MB_RX_SUM   = 31;
  localparam int unsigned MB_HW_ERR   = 29;
  localparam int unsigned MB_PERIODIC = 28;
  localparam int unsigned MB_TX_SUM   = 27;

  // DMA cause bit positions
  localparam int unsigned DB_ERR   = 31;
  localparam int unsigned DB_HIPRI = 30;
  localparam int unsigned DB_RX1   = 17;
  localparam int unsigned DB_RX0   = 16;
  localparam int unsigned DB_TX1   = 1;
  localparam int unsigned DB_TX0   = 0;

  localparam logic [REG_W-1:0] MAIN_IMPL   = 32'hBE00_00CB;
  localparam logic [REG_W-1:0] MAIN_HW_SRC = 32'h2600_00CB;
  localparam logic [REG_W-1:0] DMA_IMPL    = 32'hC003_0003;
  localparam logic [REG_W-1:0] DMA_RX_SET  = 32'h4003_0000;
  localparam logic [REG_W-1:0] DMA_TX_SET  = 32'h0000_0003;

  typedef enum logic [1:0] {
    CO_IDLE = 2'd0,
    CO_WAIT = 2'd1,
    CO_FIRE = 2'd2
  } co_state_e;

  // summary bits raised in the main register by new DMA events
  function automatic logic [REG_W-1:0] fold_dma(input logic [REG_W-1:0] d);
    logic [REG_W-1:0] r;
    r = '0;
    r[MB_RX_SUM] = |(d & DMA_RX_SET);
    r[MB_TX_SUM] = |(d & DMA_TX_SET);
    r[MB_HW_ERR] = d[DB_ERR];
    return r;
  endfunction

  function automatic logic [REG_W-1:0] main_set_vec(input logic [REG_W-1:0] hw,
                                                    input logic [REG_W-1:0] dma,
                                                    input logic             per);
    logic [REG_W-1:0] r;
    r = (hw & MAIN_HW_SRC) | fold_dma(dma);
    r[MB_PERIODIC] = r[MB_PERIODIC] | per;
    return r;
  endfunction

  // write-one-to-clear with set priority, confined to implemented bits
  function automatic logic [REG_W-1:0] w1c_next(input logic [REG_W-1:0] q,
                                                input logic [REG_W-1:0] set,
                                                input logic [REG_W-1:0] clr,
                                                input logic [REG_W-1:0] impl);
    return ((q & ~clr) | set) & impl;
  endfunction

endpackage

// File: rtl/irq_unit_tick.sv
module irq_unit_tick #(
  parameter int unsigned US_PER_UNIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick_i,
  output logic unit_o
);
  localparam int unsigned PW = (US_PER_UNIT > 1) ? $clog2(US_PER_UNIT) : 1;
  localparam logic [PW-1:0] LAST = PW'(US_PER_UNIT - 1);

  logic [PW-1:0] pre_q;

  assign unit_o = us_tick_i && (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (unit_o)    pre_q <= '0;
    else if (us_tick_i) pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/irq_w1c_reg.sv
module irq_w1c_reg
  import irq_agg_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic             clr_en_i,
  input  logic [REG_W-1:0] clr_mask_i,
  output logic [REG_W-1:0] q_o
);
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] q_d;

  assign clr_vec = clr_en_i ? clr_mask_i : '0;
  assign q_d     = w1c_next(q_o, set_i, clr_vec, IMPL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & IMPL)) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en_i && |(clr_mask_i & ~set_i & IMPL)) |=> ((q_o & $past(clr_mask_i & ~set_i)) == '0)); // R3
endmodule

// File: rtl/irq_periodic.sv
module irq_periodic #(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_i,
  input  logic [CFG_W-1:0] period_i,
  output logic             fire_o
);
  logic [CFG_W-1:0] cnt_q;
  logic             armed;
  logic             at_end;

  assign armed  = (period_i != '0);
  assign at_end = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period_i};
  assign fire_o = unit_i && armed && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!armed) cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else if (unit_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/irq_coalesce_fsm.sv
module irq_coalesce_fsm
  import irq_agg_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             unit_i,
  input  logic             pending_i,
  input  logic             hipri_i,
  input  logic [CFG_W-1:0] holdoff_i,
  output logic             irq_o
);
  co_state_e        st_q, st_d;
  logic [CFG_W-1:0] cnt_q, cnt_d;
  logic             expire;

  assign expire = unit_i && (cnt_q <= CFG_W'(1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      CO_IDLE: if (pending_i) begin
        if (hipri_i || holdoff_i == '0) st_d = CO_FIRE;
        else begin
          st_d  = CO_WAIT;
          cnt_d = holdoff_i;
        end
      end
      CO_WAIT: begin
        if (!pending_i)   st_d = CO_IDLE;
        else if (hipri_i) st_d = CO_FIRE;
        else if (expire)  st_d = CO_FIRE;
        else if (unit_i)  cnt_d = cnt_q - 1'b1;
      end
      CO_FIRE: if (!pending_i) st_d = CO_IDLE;
      default: st_d = CO_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CO_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign irq_o = (st_q == CO_FIRE) && pending_i;

  AST_HOLDOFF_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CO_WAIT && !hipri_i && !unit_i) |=> !irq_o); // R7

  AST_HIPRI_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i && hipri_i) |=> (irq_o || !pending_i)); // R8
endmodule

// File: rtl/host_irq_coalescer.sv
module host_irq_coalescer
  import irq_agg_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned CFG_W       = 8,
  parameter int unsigned US_PER_UNIT = 32,
  parameter logic [CFG_W-1:0] HOLDOFF_RST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [REG_W-1:0]  hw_evt,
  input  logic [REG_W-1:0]  dma_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              host_irq
);
  localparam int unsigned TIM_W = 2 * CFG_W;

  logic sel_cause, sel_en, sel_dma, sel_tim;
  assign sel_cause = (reg_addr == ADDR_W'(0));
  assign sel_en    = (reg_addr == ADDR_W'(1));
  assign sel_dma   = (reg_addr == ADDR_W'(2));
  assign sel_tim   = (reg_addr == ADDR_W'(3));

  // named internal events
  logic             unit_evt;
  logic             per_fire;
  logic [REG_W-1:0] main_set;
  logic [REG_W-1:0] dma_set;
  logic [REG_W-1:0] cause_q, dma_q, en_q;
  logic [CFG_W-1:0] holdoff_q, period_q;
  logic             pending, hipri;

  irq_unit_tick #(.US_PER_UNIT(US_PER_UNIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .us_tick_i(us_tick), .unit_o(unit_evt)
  );

  irq_periodic #(.CFG_W(CFG_W)) u_per (
    .clk(clk), .rst_n(rst_n), .unit_i(unit_evt), .period_i(period_q), .fire_o(per_fire)
  );

  assign dma_set  = dma_evt & DMA_IMPL;
  assign main_set = main_set_vec(hw_evt, dma_set, per_fire);

  irq_w1c_reg #(.IMPL(MAIN_IMPL)) u_main (
    .clk(clk), .rst_n(rst_n), .set_i(main_set),
    .clr_en_i(reg_wr && sel_cause), .clr_mask_i(reg_wdata), .q_o(cause_q)
  );

  irq_w1c_reg #(.IMPL(DMA_IMPL)) u_dma (
    .clk(clk), .rst_n(rst_n), .set_i(dma_set),
    .clr_en_i(reg_wr && sel_dma), .clr_mask_i(reg_wdata), .q_o(dma_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= '0;
      holdoff_q <= HOLDOFF_RST;
      period_q  <= '0;
    end else if (reg_wr) begin
      if (sel_en) en_q <= reg_wdata & MAIN_IMPL;
      if (sel_tim) begin
        holdoff_q <= reg_wdata[CFG_W-1:0];
        period_q  <= reg_wdata[TIM_W-1:CFG_W];
      end
    end
  end

  assign pending = |(cause_q & en_q);
  assign hipri   = dma_q[DB_HIPRI] && cause_q[MB_RX_SUM] && en_q[MB_RX_SUM];

  irq_coalesce_fsm #(.CFG_W(CFG_W)) u_co (
    .clk(clk), .rst_n(rst_n), .unit_i(unit_evt), .pending_i(pending),
    .hipri_i(hipri), .holdoff_i(holdoff_q), .irq_o(host_irq)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_cause) reg_rdata = cause_q;
    if (sel_en)    reg_rdata = en_q;
    if (sel_dma)   reg_rdata = dma_q;
    if (sel_tim)   reg_rdata = REG_W'({period_q, holdoff_q});
  end

  AST_DMA_FOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (|(dma_evt & DMA_RX_SET)) |=> cause_q[MB_RX_SUM]); // R5

  AST_PER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    per_fire |=> cause_q[MB_PERIODIC]); // R10
endmodule

// File: tb/host_irq_coalescer_bench.sv
module host_irq_coalescer_bench;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        us_tick = 1'b0;
  logic [31:0] hw_evt = '0;
  logic [31:0] dma_evt = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;
  bit toggle_tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_irq_coalescer u_host_irq_coalescer (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .hw_evt(hw_evt), .dma_evt(dma_evt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  // ---------------- behavioural reference ----------------
  bit [31:0] m_cause, m_dma, m_en;
  bit [7:0]  m_hold, m_per;
  int        m_phase, m_left, m_since, m_mode;  // mode 0 idle, 1 waiting, 2 raised

  function automatic bit [31:0] ref_rd(input bit [3:0] a);
    case (a)
      4'd0: return m_cause;
      4'd1: return m_en;
      4'd2: return m_dma;
      4'd3: return {16'h0, m_per, m_hold};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit ref_irq();
    return (m_mode == 2) && ((m_cause & m_en) != 0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = 0; m_dma = 0; m_en = 0; m_hold = 8'h40; m_per = 0;
      m_phase = 0; m_left = 0; m_since = 0; m_mode = 0;
    end else begin
      bit unit, pend, hi, pf;
      bit [31:0] ds, ms, mclr, dclr;
      unit = us_tick && (m_phase == 31);
      pend = (m_cause & m_en) != 0;
      hi   = m_dma[30] && m_cause[31] && m_en[31];
      pf   = unit && (m_per != 0) && (m_since + 1 >= m_per);
      if (m_mode == 0) begin
        if (pend) begin
          if (hi || m_hold == 0) m_mode = 2;
          else begin m_mode = 1; m_left = m_hold; end
        end
      end else if (m_mode == 1) begin
        if (!pend) m_mode = 0;
        else if (hi) m_mode = 2;
        else if (unit) begin
          if (m_left <= 1) m_mode = 2; else m_left = m_left - 1;
        end
      end else if (!pend) m_mode = 0;
      if (m_per == 0) m_since = 0;
      else if (unit) m_since = pf ? 0 : m_since + 1;
      if (us_tick) m_phase = (m_phase + 1) % 32;
      ds = dma_evt & 32'hC003_0003;
      ms = hw_evt & 32'h2600_00CB;
      if (ds[30] || ds[17] || ds[16]) ms[31] = 1;
      if (ds[1] || ds[0]) ms[27] = 1;
      if (ds[31]) ms[29] = 1;
      if (pf) ms[28] = 1;
      mclr = (reg_wr && reg_addr == 0) ? reg_wdata : 0;
      dclr = (reg_wr && reg_addr == 2) ? reg_wdata : 0;
      m_cause = ((m_cause & ~mclr) | ms) & 32'hBE00_00CB;
      m_dma   = ((m_dma & ~dclr) | ds) & 32'hC003_0003;
      if (reg_wr && reg_addr == 1) m_en = reg_wdata & 32'hBE00_00CB;
      if (reg_wr && reg_addr == 3) begin m_hold = reg_wdata[7:0]; m_per = reg_wdata[15:8]; end
    end
  end

  // per-cycle comparison, after the edge has settled
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      checks++;
      if (host_irq !== ref_irq()) begin
        errors++;
        $display("FAIL R7 R9 line: actual %0b expected %0b at %0t", host_irq, ref_irq(), $time);
      end
      checks++;
      if (reg_rdata !== ref_rd(reg_addr)) begin
        errors++;
        $display("FAIL %s word %0d: actual %h expected %h at %0t",
                 (reg_addr == 0) ? "R2" : (reg_addr == 2) ? "R4" : "R11",
                 reg_addr, reg_rdata, ref_rd(reg_addr), $time);
      end
    end
  end

  always @(negedge clk) us_tick <= toggle_tick ? ~us_tick : 1'b1;

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit [3:0] a, input bit [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input bit [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic pulse(input bit [31:0] h, input bit [31:0] dm);
    @(negedge clk); hw_evt = h; dma_evt = dm;
    @(negedge clk); hw_evt = 0; dma_evt = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  // ---------------- directed and stress stimulus ----------------
  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(0, d); chk("R1 cause", d, 32'h0);
    rd(1, d); chk("R1 enable", d, 32'h0);
    rd(2, d); chk("R1 dma", d, 32'h0);
    rd(3, d); chk("R1 timing", d, 32'h40);
    chk("R1 irq", host_irq, 1'b0);

    // R11 readback masks and unmapped word
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R11 enable mask", d, 32'hBE00_00CB);
    wr(3, 32'hFFFF_1234); rd(3, d); chk("R11 timing", d, 32'h1234);
    rd(4'd9, d); chk("R11 unmapped", d, 32'h0);
    wr(1, 0); wr(3, 32'h0040);

    // R2 main sources, unused hw bits ignored
    pulse(32'hFFFF_FFFF, 0); rd(0, d); chk("R2 sources", d, 32'h2600_00CB);
    // R3 partial clear, then set against clear in one cycle
    wr(0, 32'h0600_0003); rd(0, d); chk("R3 partial clear", d, 32'h2000_00C8);
    @(negedge clk); reg_wr = 1; reg_addr = 0; reg_wdata = 32'hFFFF_FFFF; hw_evt = 32'h0000_0008;
    @(negedge clk); reg_wr = 0; hw_evt = 0;
    rd(0, d); chk("R3 set wins", d, 32'h0000_0008);
    wr(0, 32'hFFFF_FFFF);

    // R4 / R5 DMA register and summary fold
    pulse(0, 32'hFFFF_FFFF); rd(2, d); chk("R4 dma bits", d, 32'hC003_0003);
    rd(0, d); chk("R5 fold all", d, 32'hA800_0000);
    wr(0, 32'hFFFF_FFFF); wr(2, 32'h0000_0001); rd(2, d); chk("R4 w1c", d, 32'hC003_0002);
    wr(2, 32'hFFFF_FFFF);
    pulse(0, 32'h0000_0002); rd(0, d); chk("R5 tx fold", d, 32'h0800_0000);
    wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);
    pulse(0, 32'h0002_0000); rd(0, d); chk("R5 rx fold", d, 32'h8000_0000);
    wr(0, 32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF);

    // R7 zero holdoff and R9 immediate drop
    wr(3, 32'h0000); wr(1, 32'h0000_0001);
    pulse(32'h1, 0); chk("R7 not yet", host_irq, 1'b0);
    @(negedge clk); chk("R7 zero holdoff", host_irq, 1'b1);
    wr(0, 32'h1); chk("R9 drop", host_irq, 1'b0);

    // R6 masked cause stays silent
    pulse(32'h2, 0); wait_cyc(5); chk("R6 masked", host_irq, 1'b0);
    rd(0, d); chk("R6 cause held", d, 32'h2);
    wr(0, 32'hFFFF_FFFF);

    // R7 holdoff of 2 units
    wr(3, 32'h0002);
    pulse(32'h1, 0); wait_cyc(30); chk("R7 holdoff low", host_irq, 1'b0);
    wait_cyc(46); chk("R7 holdoff high", host_irq, 1'b1);
    wr(0, 32'hFFFF_FFFF); chk("R9 drop timed", host_irq, 1'b0);

    // R8 bypass while a long holdoff runs
    wr(3, 32'h0040); wr(1, 32'h8000_0000);
    pulse(0, 32'h0001_0000); wait_cyc(10); chk("R7 rx waits", host_irq, 1'b0);
    pulse(0, 32'h4000_0000); chk("R8 not before edge", host_irq, 1'b0);
    @(negedge clk); chk("R8 bypass", host_irq, 1'b1);
    wr(0, 32'h8000_0000); chk("R9 summary cleared", host_irq, 1'b0);
    wr(2, 32'hFFFF_FFFF);

    // R10 periodic
    wr(1, 0); wr(3, 32'h0200); wait_cyc(70);
    rd(0, d); chk("R10 period 2", d & 32'h1000_0000, 32'h1000_0000);
    wr(3, 32'h0000); wr(0, 32'hFFFF_FFFF); wait_cyc(200);
    rd(0, d); chk("R10 disabled", d, 32'h0);
    wr(3, 32'hFF00); wait_cyc(8090);
    rd(0, d); chk("R10 255 early", d, 32'h0);
    wait_cyc(150);
    rd(0, d); chk("R10 255 fired", d, 32'h1000_0000);
    wr(3, 32'h0000); wr(0, 32'hFFFF_FFFF);

    // stress: toggling tick, mixed events and writes, compared each cycle
    toggle_tick = 1;
    wr(1, 32'hBE00_00CB); wr(3, 32'h0303);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      hw_evt  = ($urandom_range(0, 15) == 0) ? $urandom : 0;
      dma_evt = ($urandom_range(0, 20) == 0) ? $urandom : 0;
      reg_wr  = ($urandom_range(0, 12) == 0);
      reg_addr  = 4'($urandom_range(0, 4));
      reg_wdata = (reg_addr == 3) ? {16'h0, 8'($urandom_range(0, 4)), 8'($urandom_range(0, 3))}
                                  : $urandom;
    end
    @(negedge clk); hw_evt = 0; dma_evt = 0; reg_wr = 0;
    wait_cyc(3);
    finish_run();
  end
endmodule